// File: doc/BRIEF.md
# Four-lane parallel PRBS7 generator and self-synchronising checker

This block produces a maximal-length pseudo-random bit sequence of period 127 and delivers it four bits per core clock. The lanes are phase-ordered, so a 4:1 serializer placed after the generator emits the serial sequence in its natural order at four times the core rate. Each new bit is formed by a look-ahead XNOR network from bits already held in a seven-bit register. Because XNOR feedback is used, the all-zero reset state is a legal state, and no seed logic is needed. A small serializer model is part of the block, so the lane ordering can be observed as one serial bit per clock.

The checker takes a received four-lane word on every enabled clock. It loads its seven-bit history from the first two received words. It then compares each further word with the word it predicts, XORing lane by lane and ORing the results into one mismatch. After eight consecutive clean compared words it declares lock. From then on it free-runs on its own prediction, so a corrupted received bit is flagged exactly once and is not propagated. A saturating counter records how many locked words carried errors.

A single enable advances the generator, loads the serializer and makes the checker consume the received word. With the enable low, all three hold.

Top module: `prbs7_quad`

## Requirements
- R1: While reset is asserted and directly after it, the generator state is all zeros, so `gen_word_o` shows 4'b1111, and `err_o`, `locked_o`, `err_cnt_o` and `ser_bit_o` are 0.
- R2: The generated bits follow s[m] = NOT(s[m-7] XOR s[m-6]), with s[-7..-1] = 0 after reset. The word sequence repeats after 127 enabled clocks, and the internal state never becomes all ones.
- R3: Bit k (k = 0..3) of the word shown after w enabled clocks is s[4w+k]. Bit 0 is the earliest bit in serial order.
- R4: With `en_i` low, `gen_word_o` holds its value, and `rx_word_i` has no effect on `err_o`, `err_cnt_o`, `locked_o` or the checker's later predictions.
- R5: On an enabled clock, the serializer captures the current `gen_word_o`. `ser_bit_o` then shows bit 0 in the following cycle and bits 1, 2 and 3 in the next three cycles, provided `en_i` stays low.
- R6: The checker uses the first two enabled words after reset only to load its history. It sets `locked_o` after the 8th consecutive mismatch-free compared word, which is the 10th enabled clock for a clean stream. Lock stays set until reset.
- R7: Once locked, `err_o` is high for exactly one cycle after each enabled word in which any received bit differs from the prediction. A single flipped bit on any lane is flagged, and the following clean word gives no error.
- R8: Before lock, mismatches never raise `err_o` or change `err_cnt_o`. A mismatch instead restarts the clean-word run.
- R9: `err_cnt_o` is a 16-bit count of locked words that had errors. It saturates at 65535.
- R10: The checker acquires lock on a received stream that starts at any phase of the sequence, independently of the local generator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance generator, load serializer, consume received word |
| gen_word_o | output | 4 | Generated word, bit 0 earliest in serial order |
| ser_bit_o | output | 1 | Serializer model output, one lane per clock |
| rx_word_i | input | 4 | Received word, bit 0 earliest |
| err_o | output | 1 | One-cycle flag for a mismatched word while locked |
| locked_o | output | 1 | Checker has seen eight clean words in a row |
| err_cnt_o | output | 16 | Saturating count of errored locked words |

## Verification
A wrong generator state shows at once on `gen_word_o`. The next enabled clock's word departs from the bit-by-bit reference, and a state that slipped into all ones would freeze the output at 4'b1111. A corrupted checker history appears within one enabled word after lock as an `err_o` pulse on a clean loopback stream. Before lock, it appears as lock arriving later than the 10th enabled clock. Lane misordering appears within four cycles of a serializer load, because `ser_bit_o` is compared bit by bit with the reference sequence.

// File: rtl/prbs7_pkg.sv
`timescale 1ns/1ps
package prbs7_pkg;
    // Sequence definition: s[m] = ~(s[m-ORDER] ^ s[m-TAP])
    localparam int PRBS_ORDER = 7;
    localparam int PRBS_TAP   = 6;
    // Bits delivered per clock
    localparam int PRBS_LANES = 4;
    // Error counter width and clean-word run needed for lock
    localparam int PRBS_CNT_W = 16;
    localparam int PRBS_LOCK_RUN = 8;
endpackage

// File: rtl/prbs_ahead.sv
`timescale 1ns/1ps
// Look-ahead network: from ORDER history bits (bit 0 oldest) compute the
// next LANES sequence bits and the updated history. Bits produced earlier
// in the same word are reused when the look-ahead reaches past the register.
module prbs_ahead #(
    parameter int ORDER = 7,
    parameter int TAP   = 6,
    parameter int LANES = 4
) (
    input  logic [ORDER-1:0] st_i,
    output logic [LANES-1:0] word_o,
    output logic [ORDER-1:0] nxt_o
);
    localparam int EXT = ORDER + LANES;

    logic [EXT-1:0] ext;

    always_comb begin
        ext = '0;
        ext[ORDER-1:0] = st_i;
        for (int j = 0; j < LANES; j++) begin
            ext[ORDER+j] = ~(ext[j] ^ ext[j+ORDER-TAP]);
        end
    end

    assign word_o = ext[EXT-1:ORDER];
    assign nxt_o  = ext[EXT-1 -: ORDER];
endmodule

// File: rtl/prbs_gen.sv
`timescale 1ns/1ps
module prbs_gen #(
    parameter int ORDER = 7,
    parameter int TAP   = 6,
    parameter int LANES = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    output logic [LANES-1:0] word_o,
    output logic [ORDER-1:0] st_o
);
    typedef struct packed {
        logic [ORDER-1:0] st;
    } gen_t;

    gen_t             gen_d, gen_q;
    logic [ORDER-1:0] st_nxt;

    prbs_ahead #(.ORDER(ORDER), .TAP(TAP), .LANES(LANES)) u_ahead (
        .st_i   (gen_q.st),
        .word_o (word_o),
        .nxt_o  (st_nxt)
    );

    always_comb begin
        gen_d = gen_q;
        if (en_i) gen_d.st = st_nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gen_q <= '0;
        else         gen_q <= gen_d;
    end

    assign st_o = gen_q.st;
endmodule

// File: rtl/prbs_ser.sv
`timescale 1ns/1ps
// Serializer model: captures a word on enable, then shifts out lane 0 first.
module prbs_ser #(
    parameter int LANES = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [LANES-1:0] word_i,
    output logic             bit_o
);
    typedef struct packed {
        logic [LANES-1:0] sh;
    } ser_t;

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d = ser_q;
        if (en_i) ser_d.sh = word_i;
        else      ser_d.sh = ser_q.sh >> 1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ser_q <= '0;
        else         ser_q <= ser_d;
    end

    assign bit_o = ser_q.sh[0];
endmodule

// File: rtl/prbs_chk.sv
`timescale 1ns/1ps
module prbs_chk #(
    parameter int ORDER    = 7,
    parameter int TAP      = 6,
    parameter int LANES    = 4,
    parameter int CNT_W    = 16,
    parameter int LOCK_RUN = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [LANES-1:0] rx_i,
    output logic             err_o,
    output logic             locked_o,
    output logic [CNT_W-1:0] cnt_o
);
    // words needed to fill the history before predictions are valid
    localparam int FILL   = (ORDER + LANES - 1) / LANES;
    localparam int FILL_W = $clog2(FILL + 1);
    localparam int RUN_W  = $clog2(LOCK_RUN + 1);
    localparam int EXT    = ORDER + LANES;

    typedef struct packed {
        logic [ORDER-1:0]  hist;
        logic [FILL_W-1:0] fill;
        logic [RUN_W-1:0]  run;
        logic              locked;
        logic              err;
        logic [CNT_W-1:0]  cnt;
    } chk_t;

    chk_t             chk_d, chk_q;
    logic [LANES-1:0] pred;
    logic [ORDER-1:0] pred_nxt;
    logic [EXT-1:0]   rx_ext;
    logic [ORDER-1:0] rx_nxt;
    logic             mismatch;

    prbs_ahead #(.ORDER(ORDER), .TAP(TAP), .LANES(LANES)) u_pred (
        .st_i   (chk_q.hist),
        .word_o (pred),
        .nxt_o  (pred_nxt)
    );

    assign rx_ext   = {rx_i, chk_q.hist};
    assign rx_nxt   = rx_ext[EXT-1 -: ORDER];
    assign mismatch = |(rx_i ^ pred);

    always_comb begin
        chk_d     = chk_q;
        chk_d.err = 1'b0;
        if (en_i) begin
            if (chk_q.fill != FILL_W'(FILL)) begin
                chk_d.fill = chk_q.fill + 1'b1;
                chk_d.hist = rx_nxt;
            end else if (!chk_q.locked) begin
                chk_d.hist = rx_nxt;
                if (mismatch) begin
                    chk_d.run = '0;
                end else begin
                    chk_d.run = chk_q.run + 1'b1;
                    if (chk_q.run == RUN_W'(LOCK_RUN - 1)) chk_d.locked = 1'b1;
                end
            end else begin
                chk_d.hist = pred_nxt;
                if (mismatch) begin
                    chk_d.err = 1'b1;
                    if (chk_q.cnt != '1) chk_d.cnt = chk_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chk_q <= '0;
        else         chk_q <= chk_d;
    end

    assign err_o    = chk_q.err;
    assign locked_o = chk_q.locked;
    assign cnt_o    = chk_q.cnt;
endmodule

// File: rtl/prbs7_quad.sv
`timescale 1ns/1ps
module prbs7_quad
    import prbs7_pkg::*;
#(
    parameter int ORDER    = PRBS_ORDER,
    parameter int TAP      = PRBS_TAP,
    parameter int LANES    = PRBS_LANES,
    parameter int CNT_W    = PRBS_CNT_W,
    parameter int LOCK_RUN = PRBS_LOCK_RUN
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    output logic [LANES-1:0] gen_word_o,
    output logic             ser_bit_o,
    input  logic [LANES-1:0] rx_word_i,
    output logic             err_o,
    output logic             locked_o,
    output logic [CNT_W-1:0] err_cnt_o
);
    logic [ORDER-1:0] gen_st;

    prbs_gen #(.ORDER(ORDER), .TAP(TAP), .LANES(LANES)) u_gen (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .word_o (gen_word_o),
        .st_o   (gen_st)
    );

    prbs_ser #(.LANES(LANES)) u_ser (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .word_i (gen_word_o),
        .bit_o  (ser_bit_o)
    );

    prbs_chk #(
        .ORDER(ORDER), .TAP(TAP), .LANES(LANES),
        .CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN)
    ) u_chk (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (en_i),
        .rx_i     (rx_word_i),
        .err_o    (err_o),
        .locked_o (locked_o),
        .cnt_o    (err_cnt_o)
    );
endmodule

module prbs7_quad_sva #(
    parameter int ORDER = 7,
    parameter int LANES = 4,
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic [LANES-1:0] gen_word_o,
    input logic [ORDER-1:0] gen_st,
    input logic             err_o,
    input logic             locked_o,
    input logic [CNT_W-1:0] err_cnt_o
);
    p_no_lockup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gen_st != '1);

    p_gen_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(gen_word_o));

    p_lock_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_o |=> locked_o);

    p_err_after_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> $past(en_i));

    p_err_needs_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> locked_o);

    p_cnt_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(err_cnt_o) |-> (err_o && err_cnt_o == $past(err_cnt_o) + 1'b1));

    p_cnt_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(err_cnt_o) == '1) |-> (err_cnt_o == '1));
endmodule

bind prbs7_quad prbs7_quad_sva #(.ORDER(ORDER), .LANES(LANES), .CNT_W(CNT_W)) u_sva (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .gen_word_o (gen_word_o),
    .gen_st     (gen_st),
    .err_o      (err_o),
    .locked_o   (locked_o),
    .err_cnt_o  (err_cnt_o)
);

// File: tb/tb_prbs7_quad.sv
`timescale 1ns/1ps
module tb_prbs7_quad;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [3:0]  gen_word;
    logic        ser_bit;
    logic [3:0]  rx_word;
    logic        err;
    logic        locked;
    logic [15:0] err_cnt;

    logic        rx_sel = 1'b0;
    logic [3:0]  inj = 4'h0;
    logic [3:0]  model_word = 4'h0;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic seq [0:126];

    // table: {expected err, injected mask}
    localparam logic [4:0] VEC [8] = '{
        5'b1_0001, 5'b1_0010, 5'b1_0100, 5'b1_1000,
        5'b0_0000, 5'b1_0101, 5'b1_1111, 5'b0_0000
    };

    always #10 clk = ~clk;

    assign rx_word = rx_sel ? model_word : (gen_word ^ inj);

    prbs7_quad dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .gen_word_o (gen_word),
        .ser_bit_o  (ser_bit),
        .rx_word_i  (rx_word),
        .err_o      (err),
        .locked_o   (locked),
        .err_cnt_o  (err_cnt)
    );

    function automatic logic [3:0] ref_word(input int w);
        logic [3:0] r;
        for (int k = 0; k < 4; k++) r[k] = seq[(4 * w + k) % 127];
        return r;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        en    = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int widx;
        logic [3:0] w0;
        logic [3:0] held;
        logic [3:0] wd;
        int ecnt;

        for (int i = 0; i < 127; i++) begin
            logic a, b;
            a = (i >= 7) ? seq[i-7] : 1'b0;
            b = (i >= 6) ? seq[i-6] : 1'b0;
            seq[i] = ~(a ^ b);
        end

        // R1 reset state
        step();
        check("R1 gen word in reset", gen_word, 4'hF);
        do_reset();
        check("R1 gen word", gen_word, 4'hF);
        check("R1 err", err, 0);
        check("R1 locked", locked, 0);
        check("R1 count", err_cnt, 0);
        check("R1 serial bit", ser_bit, 0);

        // R2/R3/R6 loopback run
        widx = 0;
        w0 = gen_word;
        for (int w = 0; w < 140; w++) begin
            check("R3 lane order", gen_word, ref_word(w));
            if (w == 127) check("R2 period 127", gen_word, w0);
            en = 1'b1;
            step();
            widx++;
            if (w + 1 == 9)  check("R6 not locked at 9", locked, 0);
            if (w + 1 == 10) check("R6 locked at 10", locked, 1);
            if (err !== 1'b0) check("R7 clean loopback err", err, 0);
        end
        check("R8 count after clean run", err_cnt, 0);

        // R4 enable low: hold and ignore rx
        en = 1'b0;
        held = gen_word;
        rx_sel = 1'b1;
        for (int i = 0; i < 5; i++) begin
            model_word = 4'(i * 5 + 3);
            step();
        end
        check("R4 gen word held", gen_word, held);
        check("R4 err unaffected", err, 0);
        check("R4 count unaffected", err_cnt, 0);
        rx_sel = 1'b0;
        en = 1'b1;
        step();
        widx++;
        check("R4 checker state untouched", err, 0);
        check("R4 gen resumes", gen_word, ref_word(widx));

        // R7 table of injected patterns while locked
        ecnt = 0;
        for (int v = 0; v < 8; v++) begin
            inj = VEC[v][3:0];
            en = 1'b1;
            step();
            widx++;
            if (VEC[v][4]) ecnt++;
            check("R7 err flag", err, VEC[v][4]);
            check("R9 count", err_cnt, ecnt);
            inj = 4'h0;
            step();
            widx++;
            check("R7 no propagation", err, 0);
        end

        // R5 serializer ordering
        for (int n = 0; n < 3; n++) begin
            wd = gen_word;
            check("R3 word before load", wd, ref_word(widx));
            en = 1'b1;
            step();
            en = 1'b0;
            for (int k = 0; k < 4; k++) begin
                check("R5 serial bit", ser_bit, seq[(4 * widx + k) % 127]);
                if (k < 3) step();
            end
            widx++;
        end

        // R8/R10 acquire on a foreign phase with a pre-lock error
        do_reset();
        rx_sel = 1'b1;
        for (int e = 0; e < 30; e++) begin
            model_word = ref_word(37 + e) ^ ((e == 4) ? 4'b0100 : 4'b0000);
            en = 1'b1;
            step();
            if (e + 1 == 10) check("R8 lock delayed by pre-lock error", locked, 0);
            if (err !== 1'b0) check("R8 no err before lock", err, 0);
        end
        check("R10 locked on foreign phase", locked, 1);
        check("R8 count after pre-lock error", err_cnt, 0);
        model_word = ref_word(37 + 30) ^ 4'b0010;
        step();
        check("R10 error detected on foreign phase", err, 1);
        check("R10 count", err_cnt, 1);
        model_word = ref_word(37 + 31);
        step();
        check("R10 clean after error", err, 0);

        // R9 saturation
        for (int n = 32; n < 32 + 65540; n++) begin
            model_word = ref_word(37 + n) ^ 4'b1000;
            step();
        end
        check("R9 saturated", err_cnt, 16'hFFFF);
        check("R9 err still flagged", err, 1);
        model_word = ref_word(37 + 32 + 65540) ^ 4'b0001;
        step();
        check("R9 stays saturated", err_cnt, 16'hFFFF);

        en = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule